// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Process Tags

The block holds a small set of recent virtual-to-physical page translations. Every entry carries a valid flag, a virtual page number, a process tag and a physical frame number. A lookup compares all entries at the same time. A hit returns the physical address in the same cycle as the lookup. That address is the stored frame number placed above the untouched page offset. A miss raises a walk request in the same cycle, carrying the page number and process tag that were missed. The page table walker sits outside the block. It later returns the translation on the refill channel.

A refill goes to one of three places, in this order. If an entry already holds the same page number and process tag, the refill overwrites that entry. Otherwise it takes the lowest-numbered empty entry. Otherwise it takes the entry least recently used. Every hit and every refill marks the entry it touched as most recently used. When the mode input `pid_chk` is high, a hit also needs the process tag to match, so a context switch can leave the entries in place. When `pid_chk` is low, the process tag is ignored and software uses `flush`, which empties the whole buffer in one cycle.

Both data channels use valid/ready. A lookup is accepted only while `lk_ready` is high, and `lk_ready` is held low during a flush cycle and during any cycle that offers a refill. A refill is accepted only while `fill_ready` is high, and `fill_ready` is held low only during a flush cycle. The source keeps a request steady until it is accepted. The lookup result has no ready: it is valid only in the cycle the lookup is accepted.

Top module: `tlb_fa_pid`

## Requirements
- R1: An accepted lookup hits when some valid entry holds the lookup page number (and, with `pid_chk`=1, the lookup process tag). When several entries match, the lowest-numbered one is used.
- R2: On a hit, `res_hit`=1 in the same cycle and `res_paddr` = {stored frame number, lookup offset bits [OFF_W-1:0]}.
- R3: On an accepted lookup that misses, `walk_req`=1 in the same cycle, with `walk_vpn` and `walk_pid` equal to the lookup page number and tag. `walk_req` and `res_hit` are never high together, and both are low when no lookup is accepted.
- R4: An accepted refill installs its page number, tag and frame number, so a lookup in any later cycle hits with the new frame number.
- R5: A refill that matches no entry takes the lowest-numbered invalid entry. If none is invalid, it replaces the entry whose last hit or refill is oldest.
- R6: A refill whose page number and tag both equal those of a valid entry overwrites that entry, whatever `pid_chk` is. The number of valid entries does not change.
- R7: An accepted `flush` invalidates every entry at the clock edge, so every lookup from the next cycle on misses until new refills arrive.
- R8: With `pid_chk`=1, an entry whose tag differs from `lk_pid` never hits. With `pid_chk`=0, the tag does not affect hit or miss.
- R9: `lk_ready` = not (`flush` or `fill_valid`) and `fill_ready` = not `flush`. A lookup or refill that is not accepted produces no result, changes no entry and leaves the replacement order as it was.
- R10: After reset every entry is invalid, and both ready outputs are high while `flush` and `fill_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate every entry at this edge |
| pid_chk | input | 1 | 1: a hit needs the process tag to match |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup accepted this cycle |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address of the lookup |
| lk_pid | input | PID_W | Process tag of the lookup |
| res_hit | output | 1 | Accepted lookup hit |
| res_paddr | output | PFN_W+OFF_W | Physical address, valid while res_hit |
| walk_req | output | 1 | Accepted lookup missed; a walk is needed |
| walk_vpn | output | VPN_W | Page number to walk |
| walk_pid | output | PID_W | Process tag of the walk |
| fill_valid | input | 1 | Refill from the walker present |
| fill_ready | output | 1 | Refill accepted this cycle |
| fill_vpn | input | VPN_W | Refill page number |
| fill_pid | input | PID_W | Refill process tag |
| fill_pfn | input | PFN_W | Refill frame number |

## Verification
The lookup outputs `res_hit`, `res_paddr`, `walk_req`, `walk_vpn`, `walk_pid` and the two ready outputs are combinational, so they are due in the same cycle as the inputs. The bench drives inputs just after the falling edge and samples 1 ns later, before the next rising edge. Refills, flushes and replacement-order updates take effect at the rising edge. The bench's reference model applies them right after that edge, so they show up in the next lookup. Eviction order is never read directly: it is shown by which page numbers still hit in later lookups.

// File: rtl/tlb_fa_pkg.sv
package tlb_fa_pkg;

  // Where a refill is written
  typedef enum logic [1:0] {
    FILL_NONE  = 2'd0,
    FILL_DUP   = 2'd1,
    FILL_FREE  = 2'd2,
    FILL_EVICT = 2'd3
  } fill_kind_e;

endpackage

// File: rtl/tlb_fa_prio.sv
// Lowest-index-first priority encoder
module tlb_fa_prio #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign any = |vec;

endmodule

// File: rtl/tlb_fa_store.sv
// Entry storage: valid flag, page number, process tag, frame number
module tlb_fa_store #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  parameter int PFN_W = 20,
  parameter int IDX_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [VPN_W-1:0]           wr_vpn,
  input  logic [PID_W-1:0]           wr_pid,
  input  logic [PFN_W-1:0]           wr_pfn,
  output logic [N-1:0]               valid_vec,
  output logic [N-1:0][VPN_W-1:0]    ent_vpn,
  output logic [N-1:0][PID_W-1:0]    ent_pid,
  output logic [N-1:0][PFN_W-1:0]    ent_pfn
);

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic             v_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PID_W-1:0] pid_q;
    logic [PFN_W-1:0] pfn_q;
    logic             sel;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
      end else if (flush) begin
        v_q <= 1'b0;
      end else if (sel) begin
        v_q <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vpn_q <= '0;
        pid_q <= '0;
        pfn_q <= '0;
      end else if (sel && !flush) begin
        vpn_q <= wr_vpn;
        pid_q <= wr_pid;
        pfn_q <= wr_pfn;
      end
    end

    assign valid_vec[g] = v_q;
    assign ent_vpn[g]   = vpn_q;
    assign ent_pid[g]   = pid_q;
    assign ent_pfn[g]   = pfn_q;
  end

endmodule

// File: rtl/tlb_fa_match.sv
// Parallel comparators for lookup, refill duplicate check and free slot
module tlb_fa_match #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]            valid_vec,
  input  logic [N-1:0][VPN_W-1:0] ent_vpn,
  input  logic [N-1:0][PID_W-1:0] ent_pid,
  input  logic                    pid_chk,
  input  logic [VPN_W-1:0]        lk_vpn,
  input  logic [PID_W-1:0]        lk_pid,
  input  logic [VPN_W-1:0]        fl_vpn,
  input  logic [PID_W-1:0]        fl_pid,
  output logic                    lk_hit,
  output logic [IDX_W-1:0]        lk_idx,
  output logic                    dup_hit,
  output logic [IDX_W-1:0]        dup_idx,
  output logic                    has_free,
  output logic [IDX_W-1:0]        free_idx
);

  logic [N-1:0] lk_vec;
  logic [N-1:0] dup_vec;
  logic [N-1:0] free_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic lk_vpn_eq;
    logic lk_pid_ok;
    assign lk_vpn_eq  = (ent_vpn[g] == lk_vpn);
    assign lk_pid_ok  = !pid_chk || (ent_pid[g] == lk_pid);
    assign lk_vec[g]  = valid_vec[g] && lk_vpn_eq && lk_pid_ok;
    assign dup_vec[g] = valid_vec[g] && (ent_vpn[g] == fl_vpn) && (ent_pid[g] == fl_pid);
    assign free_vec[g] = !valid_vec[g];
  end

  tlb_fa_prio #(.N(N), .IDX_W(IDX_W)) i_prio_lk (
    .vec (lk_vec),
    .any (lk_hit),
    .idx (lk_idx)
  );

  tlb_fa_prio #(.N(N), .IDX_W(IDX_W)) i_prio_dup (
    .vec (dup_vec),
    .any (dup_hit),
    .idx (dup_idx)
  );

  tlb_fa_prio #(.N(N), .IDX_W(IDX_W)) i_prio_free (
    .vec (free_vec),
    .any (has_free),
    .idx (free_idx)
  );

endmodule

// File: rtl/tlb_fa_lru.sv
// True LRU by age ranks: 0 = most recent, N-1 = victim
module tlb_fa_lru #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [N-1:0]     oldest_vec,
  output logic [IDX_W-1:0] victim_idx
);

  localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(N - 1);

  logic [N-1:0][IDX_W-1:0] age_vec;
  logic [IDX_W-1:0]        touch_age;
  logic                    unused_any;

  assign touch_age = age_vec[touch_idx];

  for (genvar g = 0; g < N; g++) begin : g_age
    logic [IDX_W-1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age_q <= IDX_W'(g);
      end else if (touch) begin
        if (touch_idx == IDX_W'(g)) begin
          age_q <= '0;
        end else if (age_q < touch_age) begin
          age_q <= age_q + 1'b1;
        end
      end
    end

    assign age_vec[g]    = age_q;
    assign oldest_vec[g] = (age_q == AGE_MAX);
  end

  tlb_fa_prio #(.N(N), .IDX_W(IDX_W)) i_prio_old (
    .vec (oldest_vec),
    .any (unused_any),
    .idx (victim_idx)
  );

endmodule

// File: rtl/tlb_fa_pid.sv
module tlb_fa_pid
  import tlb_fa_pkg::*;
#(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int OFF_W = 12,
  parameter int PID_W = 8,
  parameter int PFN_W = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   pid_chk,
  input  logic                   lk_valid,
  output logic                   lk_ready,
  input  logic [VPN_W+OFF_W-1:0] lk_vaddr,
  input  logic [PID_W-1:0]       lk_pid,
  output logic                   res_hit,
  output logic [PFN_W+OFF_W-1:0] res_paddr,
  output logic                   walk_req,
  output logic [VPN_W-1:0]       walk_vpn,
  output logic [PID_W-1:0]       walk_pid,
  input  logic                   fill_valid,
  output logic                   fill_ready,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PID_W-1:0]       fill_pid,
  input  logic [PFN_W-1:0]       fill_pfn
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [VPN_W-1:0] lk_vpn;
  logic [OFF_W-1:0] lk_off;
  logic             lk_fire;
  logic             fill_fire;

  logic [N-1:0]            valid_vec;
  logic [N-1:0][VPN_W-1:0] ent_vpn;
  logic [N-1:0][PID_W-1:0] ent_pid;
  logic [N-1:0][PFN_W-1:0] ent_pfn;

  logic             lk_hit;
  logic [IDX_W-1:0] lk_idx;
  logic             fill_dup;
  logic [IDX_W-1:0] dup_idx;
  logic             has_free;
  logic [IDX_W-1:0] free_idx;
  logic [N-1:0]     oldest_vec;
  logic [IDX_W-1:0] victim_idx;

  fill_kind_e       fill_kind;
  logic [IDX_W-1:0] wr_idx;
  logic             touch;
  logic [IDX_W-1:0] touch_idx;

  assign lk_vpn = lk_vaddr[VPN_W+OFF_W-1:OFF_W];
  assign lk_off = lk_vaddr[OFF_W-1:0];

  // Handshake: a refill or flush takes the cycle from lookups
  assign lk_ready   = !flush && !fill_valid;
  assign fill_ready = !flush;
  assign lk_fire    = lk_valid && lk_ready;
  assign fill_fire  = fill_valid && fill_ready;

  tlb_fa_store #(
    .N(N), .VPN_W(VPN_W), .PID_W(PID_W), .PFN_W(PFN_W), .IDX_W(IDX_W)
  ) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .wr_en     (fill_fire),
    .wr_idx    (wr_idx),
    .wr_vpn    (fill_vpn),
    .wr_pid    (fill_pid),
    .wr_pfn    (fill_pfn),
    .valid_vec (valid_vec),
    .ent_vpn   (ent_vpn),
    .ent_pid   (ent_pid),
    .ent_pfn   (ent_pfn)
  );

  tlb_fa_match #(
    .N(N), .VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W)
  ) i_match (
    .valid_vec (valid_vec),
    .ent_vpn   (ent_vpn),
    .ent_pid   (ent_pid),
    .pid_chk   (pid_chk),
    .lk_vpn    (lk_vpn),
    .lk_pid    (lk_pid),
    .fl_vpn    (fill_vpn),
    .fl_pid    (fill_pid),
    .lk_hit    (lk_hit),
    .lk_idx    (lk_idx),
    .dup_hit   (fill_dup),
    .dup_idx   (dup_idx),
    .has_free  (has_free),
    .free_idx  (free_idx)
  );

  tlb_fa_lru #(.N(N), .IDX_W(IDX_W)) i_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch      (touch),
    .touch_idx  (touch_idx),
    .oldest_vec (oldest_vec),
    .victim_idx (victim_idx)
  );

  // Refill placement: duplicate, then free slot, then LRU victim
  always_comb begin
    if (!fill_fire)    fill_kind = FILL_NONE;
    else if (fill_dup) fill_kind = FILL_DUP;
    else if (has_free) fill_kind = FILL_FREE;
    else               fill_kind = FILL_EVICT;
  end

  always_comb begin
    unique case (fill_kind)
      FILL_DUP:   wr_idx = dup_idx;
      FILL_FREE:  wr_idx = free_idx;
      FILL_EVICT: wr_idx = victim_idx;
      default:    wr_idx = '0;
    endcase
  end

  assign touch     = fill_fire || (lk_fire && lk_hit);
  assign touch_idx = fill_fire ? wr_idx : lk_idx;

  // Lookup results, same cycle
  assign res_hit   = lk_fire && lk_hit;
  assign res_paddr = {ent_pfn[lk_idx], lk_off};
  assign walk_req  = lk_fire && !lk_hit;
  assign walk_vpn  = lk_vpn;
  assign walk_pid  = lk_pid;

endmodule

// File: rtl/tlb_fa_pid_chk.sv
module tlb_fa_pid_chk #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int OFF_W = 12,
  parameter int PFN_W = 20
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   flush,
  input logic                   lk_valid,
  input logic                   lk_ready,
  input logic [VPN_W+OFF_W-1:0] lk_vaddr,
  input logic                   res_hit,
  input logic [PFN_W+OFF_W-1:0] res_paddr,
  input logic                   walk_req,
  input logic                   fill_valid,
  input logic                   fill_ready,
  input logic [N-1:0]           valid_vec,
  input logic                   fill_dup,
  input logic [N-1:0]           oldest_vec
);

  logic fill_fire;
  assign fill_fire = fill_valid && fill_ready;

  AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (res_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0])); // R2

  AST_HIT_WALK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_hit && walk_req)); // R3

  AST_WALK_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req || res_hit) |-> (lk_valid && lk_ready)); // R3

  AST_FILL_GROWS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && !fill_dup && (valid_vec != {N{1'b1}})) |=>
      ($countones(valid_vec) == $countones($past(valid_vec)) + 1)); // R4

  AST_LRU_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1); // R5

  AST_DUP_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && fill_dup) |=> (valid_vec == $past(valid_vec))); // R6

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0)); // R7

  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!lk_ready && !fill_ready && !res_hit && !walk_req)); // R9

endmodule

bind tlb_fa_pid tlb_fa_pid_chk #(
  .N(N), .VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .lk_valid   (lk_valid),
  .lk_ready   (lk_ready),
  .lk_vaddr   (lk_vaddr),
  .res_hit    (res_hit),
  .res_paddr  (res_paddr),
  .walk_req   (walk_req),
  .fill_valid (fill_valid),
  .fill_ready (fill_ready),
  .valid_vec  (valid_vec),
  .fill_dup   (fill_dup),
  .oldest_vec (oldest_vec)
);

// File: tb/test_tlb_fa_pid.sv
`timescale 1ns/1ps
module test_tlb_fa_pid;

  localparam int N     = 4;
  localparam int VPN_W = 4;
  localparam int OFF_W = 2;
  localparam int PID_W = 2;
  localparam int PFN_W = 4;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   flush = 1'b0;
  logic                   pid_chk = 1'b0;
  logic                   lk_valid = 1'b0;
  logic                   lk_ready;
  logic [VPN_W+OFF_W-1:0] lk_vaddr = '0;
  logic [PID_W-1:0]       lk_pid = '0;
  logic                   res_hit;
  logic [PFN_W+OFF_W-1:0] res_paddr;
  logic                   walk_req;
  logic [VPN_W-1:0]       walk_vpn;
  logic [PID_W-1:0]       walk_pid;
  logic                   fill_valid = 1'b0;
  logic                   fill_ready;
  logic [VPN_W-1:0]       fill_vpn = '0;
  logic [PID_W-1:0]       fill_pid = '0;
  logic [PFN_W-1:0]       fill_pfn = '0;

  always #2.5 clk = ~clk;

  tlb_fa_pid #(
    .N(N), .VPN_W(VPN_W), .OFF_W(OFF_W), .PID_W(PID_W), .PFN_W(PFN_W)
  ) i_tlb_fa_pid (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pid_chk(pid_chk),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
    .res_hit(res_hit), .res_paddr(res_paddr), .walk_req(walk_req),
    .walk_vpn(walk_vpn), .walk_pid(walk_pid),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_pid(fill_pid), .fill_pfn(fill_pfn)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Reference model
  bit m_valid [N];
  int m_vpn   [N];
  int m_pid   [N];
  int m_pfn   [N];
  int m_stamp [N];
  int tick = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int model_find(input int vpn, input int pid, input bit chk);
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_vpn[i] == vpn && (!chk || m_pid[i] == pid)) return i;
    return -1;
  endfunction

  function automatic int model_slot(input int vpn, input int pid);
    int best;
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_vpn[i] == vpn && m_pid[i] == pid) return i;
    for (int i = 0; i < N; i++)
      if (!m_valid[i]) return i;
    best = 0;
    for (int i = 1; i < N; i++)
      if (m_stamp[i] < m_stamp[best]) best = i;
    return best;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < N; i++) m_valid[i] = 0;
  endtask

  task automatic do_lookup(input int vpn, input int off, input int pid,
                           input bit chk, input string req);
    int idx;
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vaddr = {VPN_W'(vpn), OFF_W'(off)};
    lk_pid   = PID_W'(pid);
    pid_chk  = chk;
    #1;
    idx = model_find(vpn, pid, chk);
    check(req, "hit", 32'(res_hit), (idx >= 0) ? 32'd1 : 32'd0);
    if (idx >= 0) begin
      check("R2", "paddr", 32'(res_paddr), 32'((m_pfn[idx] << OFF_W) | off));
    end else begin
      check("R3", "walk_req", 32'(walk_req), 32'd1);
      check("R3", "walk_vpn/pid", {16'(walk_vpn), 16'(walk_pid)},
            {16'(vpn), 16'(pid)});
    end
    @(posedge clk);
    if (idx >= 0) m_stamp[idx] = ++tick;
    #1 lk_valid = 1'b0;
  endtask

  task automatic do_fill(input int vpn, input int pid, input int pfn);
    int slot;
    @(negedge clk);
    fill_valid = 1'b1;
    fill_vpn = VPN_W'(vpn);
    fill_pid = PID_W'(pid);
    fill_pfn = PFN_W'(pfn);
    #1;
    check("R9", "fill_ready", 32'(fill_ready), 32'd1);
    @(posedge clk);
    slot = model_slot(vpn, pid);
    m_valid[slot] = 1; m_vpn[slot] = vpn; m_pid[slot] = pid; m_pfn[slot] = pfn;
    m_stamp[slot] = ++tick;
    #1 fill_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    #1;
    check("R9", "lk_ready in flush", 32'(lk_ready), 32'd0);
    check("R9", "fill_ready in flush", 32'(fill_ready), 32'd0);
    @(posedge clk);
    model_clear();
    #1 flush = 1'b0;
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < (1 << VPN_W); v++)
      for (int p = 0; p < (1 << PID_W); p++)
        for (int c = 0; c < 2; c++)
          do_lookup(v, (v + p) % (1 << OFF_W), p, c[0], req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10: reset state
    @(negedge clk); #1;
    check("R10", "lk_ready", 32'(lk_ready), 32'd1);
    check("R10", "fill_ready", 32'(fill_ready), 32'd1);
    for (int v = 0; v < (1 << VPN_W); v++) do_lookup(v, 0, 0, 0, "R10");

    // R4 R5: fill invalid slots, then full sweep in both tag modes (R1 R8)
    do_fill(1, 0, 9); do_fill(2, 1, 10); do_fill(3, 2, 11); do_fill(4, 3, 12);
    sweep("R1");
    sweep("R8");

    // R5: evictions by least recent use, touch order by lookups
    do_lookup(1, 1, 0, 1, "R4");
    do_fill(7, 1, 5);
    do_fill(8, 2, 6);
    sweep("R5");

    // R6: refill with same page number and tag overwrites in place
    do_fill(7, 1, 13);
    do_fill(7, 1, 14);
    sweep("R6");

    // R1 R8: same page, several tags; tag-off picks lowest index
    do_flush();
    do_fill(5, 3, 1); do_fill(5, 1, 2); do_fill(5, 2, 3); do_fill(6, 0, 4);
    for (int p = 0; p < 4; p++) begin
      do_lookup(5, p, p, 1, "R8");
      do_lookup(5, p, p, 0, "R1");
    end

    // R9: flush with lookup and refill offered together
    @(negedge clk);
    flush = 1'b1; lk_valid = 1'b1; fill_valid = 1'b1;
    lk_vaddr = {VPN_W'(6), OFF_W'(0)}; lk_pid = '0; pid_chk = 1'b0;
    fill_vpn = 4'd9; fill_pid = 2'd0; fill_pfn = 4'd7;
    #1;
    check("R9", "lk_ready", 32'(lk_ready), 32'd0);
    check("R9", "fill_ready", 32'(fill_ready), 32'd0);
    check("R9", "res_hit blocked", 32'(res_hit), 32'd0);
    check("R9", "walk_req blocked", 32'(walk_req), 32'd0);
    @(posedge clk);
    model_clear();
    #1 flush = 1'b0; lk_valid = 1'b0; fill_valid = 1'b0;
    // R7: everything misses, refused refill left nothing
    sweep("R7");

    // R9: lookup stalled while a refill is offered
    do_fill(2, 0, 3);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 4'd3; fill_pid = 2'd0; fill_pfn = 4'd8;
    lk_valid = 1'b1; lk_vaddr = {VPN_W'(2), OFF_W'(1)}; lk_pid = '0; pid_chk = 1'b1;
    #1;
    check("R9", "lk_ready with fill", 32'(lk_ready), 32'd0);
    check("R9", "no hit with fill", 32'(res_hit), 32'd0);
    check("R9", "no walk with fill", 32'(walk_req), 32'd0);
    check("R9", "fill_ready", 32'(fill_ready), 32'd1);
    @(posedge clk);
    begin
      int s;
      s = model_slot(3, 0);
      m_valid[s] = 1; m_vpn[s] = 3; m_pid[s] = 0; m_pfn[s] = 8; m_stamp[s] = ++tick;
    end
    #1 fill_valid = 1'b0; lk_valid = 1'b0;
    do_fill(4, 0, 1); do_fill(5, 0, 2); do_fill(6, 0, 4);
    sweep("R5");

    // Mixed pseudo-random traffic against the model
    lf = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[3:0] == 4'd0) do_flush();
      else if (lf[3:0] < 4'd6) do_fill(int'(lf[7:4]) & 7, int'(lf[9:8]), int'(lf[13:10]));
      else do_lookup(int'(lf[7:4]) & 7, int'(lf[11:10]), int'(lf[9:8]), lf[12], "R4");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule